// File: doc/BRIEF.md
# Dual-Limit Window Watch Comparator

This block watches a stream of signed conversion samples and flags those that cross either of two programmable thresholds. Each threshold arrives as a limit word. The word carries a magnitude, a sign bit and a direction bit. The direction bit chooses whether the threshold trips when the sample lies above it or below it.

With one threshold set to trip above and the other to trip below, the pair detects a sample outside a band. With the directions swapped, it detects a sample inside the band. Both cases use the same structure.

A sample is examined only in the cycle its valid strobe is high. Each threshold owns a sticky status bit, and the interrupt output is high while either bit is set. Software clears the status bits one by one by writing ones to the clear input. A threshold hit in the same cycle as its clear keeps the bit set, so an event is never lost.

Top module: `win_watch`

## Requirements
- R1: After reset, both status bits and the interrupt output are 0.
- R2: A limit word holds the magnitude in bits [MAG_W-1:0], the sign in bit MAG_W (1 = negative) and the direction in bit MAG_W+1. The value is sign-magnitude, and a negative zero compares equal to zero.
- R3: When the direction bit is 1, the limit trips when the sample is strictly greater than the limit value. An equal sample does not trip it.
- R4: When the direction bit is 0, the limit trips when the sample is strictly less than the limit value. An equal sample does not trip it.
- R5: A sample with the valid strobe low changes no status bit.
- R6: A set status bit stays set while no clear reaches it, including across later samples that do not trip its limit.
- R7: A 1 in bit i of `clr_stat` clears status bit i on that clock edge. A 0 leaves bit i unchanged.
- R8: When a limit trips in the same cycle as the clear of its status bit, the bit is set after the edge.
- R9: `irq` is high exactly when at least one status bit is set. Status and `irq` reflect a sample on the clock edge that accepts it.
- R10: Limit 1 above and limit 2 below flag samples outside the band. Limit 1 below and limit 2 above set both status bits for samples inside the band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp_val | input | MAG_W+1 | Sample, two's complement |
| lim_a | input | MAG_W+2 | Limit 1 word: direction, sign, magnitude |
| lim_b | input | MAG_W+2 | Limit 2 word: direction, sign, magnitude |
| clr_stat | input | 2 | Write-one-to-clear, one bit per status bit |
| stat | output | 2 | Sticky status; bit 0 is limit 1, bit 1 is limit 2 |
| irq | output | 1 | OR of the status bits |

## Verification
Two functions can fall in the same cycle: a limit tripping on a valid sample, and a software clear of that limit's status bit. The bench first sets a status bit. It then drives a tripping sample with its strobe together with a one on the matching clear bit for a single edge. The bit and `irq` must still read 1 after that edge. Separate edges with only a clear or only a non-tripping sample show that each function works on its own.

// File: rtl/win_watch_pkg.sv
package win_watch_pkg;
   typedef enum logic {
      DIR_BELOW = 1'b0,
      DIR_ABOVE = 1'b1
   } trip_dir_e;

   localparam int unsigned NUM_LIMITS = 2;
endpackage

// File: rtl/limit_cmp.sv
module limit_cmp
   import win_watch_pkg::*;
#(
   parameter int unsigned MAG_W     = 8,
   parameter bit          INCLUSIVE = 1'b0
) (
   input  logic [MAG_W+1:0]        lim_word,
   input  logic signed [MAG_W:0]   sample,
   output logic                    trip
);
   localparam int unsigned EXT_W = MAG_W + 2;

   logic [MAG_W-1:0]         mag;
   logic                     neg;
   trip_dir_e                dir;
   logic signed [EXT_W-1:0]  lim_tc;
   logic signed [EXT_W-1:0]  smp_x;
   logic                     above;
   logic                     below;

   assign mag = lim_word[MAG_W-1:0];
   assign neg = lim_word[MAG_W];
   assign dir = trip_dir_e'(lim_word[MAG_W+1]);

   // sign-magnitude to two's complement; -0 collapses to 0
   always_comb begin
      lim_tc = $signed({2'b00, mag});
      if (neg) lim_tc = -$signed({2'b00, mag});
   end

   assign smp_x = {sample[MAG_W], sample};

   generate
      if (INCLUSIVE) begin : g_incl
         assign above = (smp_x >= lim_tc);
         assign below = (smp_x <= lim_tc);
      end else begin : g_strict
         assign above = (smp_x > lim_tc);
         assign below = (smp_x < lim_tc);
      end
   endgenerate

   assign trip = (dir == DIR_ABOVE) ? above : below;
endmodule

// File: rtl/sticky_bit.sv
module sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/win_watch.sv
module win_watch
   import win_watch_pkg::*;
#(
   parameter int unsigned MAG_W     = 8,
   parameter bit          INCLUSIVE = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  smp_vld,
   input  logic [MAG_W:0]        smp_val,
   input  logic [MAG_W+1:0]      lim_a,
   input  logic [MAG_W+1:0]      lim_b,
   input  logic [1:0]            clr_stat,
   output logic [1:0]            stat,
   output logic                  irq
);
   localparam int unsigned LW = MAG_W + 2;

   generate
      if (MAG_W < 2 || MAG_W > 30) begin : g_bad_width
         $error("win_watch: MAG_W out of range");
      end
      if (NUM_LIMITS != 2) begin : g_bad_count
         $error("win_watch: limit count must be 2");
      end
   endgenerate

   logic [LW-1:0] lim_arr [NUM_LIMITS];
   logic [NUM_LIMITS-1:0] trip;

   assign lim_arr[0] = lim_a;
   assign lim_arr[1] = lim_b;

   generate
      for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_lim
         limit_cmp #(.MAG_W(MAG_W), .INCLUSIVE(INCLUSIVE)) u_cmp (
            .lim_word (lim_arr[i]),
            .sample   ($signed(smp_val)),
            .trip     (trip[i])
         );

         sticky_bit u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (smp_vld && trip[i]),
            .clr_i  (clr_stat[i]),
            .flag_o (stat[i])
         );

         assert_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[i]) |-> $past(smp_vld));
      end
   endgenerate

   assign irq = |stat;

   assert_irq_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && |trip) |=> irq);
endmodule

// File: tb/sim_win_watch.sv
module sim_win_watch;
   localparam int unsigned MAG_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             smp_vld = 1'b0;
   logic [MAG_W:0]   smp_val = '0;
   logic [MAG_W+1:0] lim_a = '0;
   logic [MAG_W+1:0] lim_b = '0;
   logic [1:0]       clr_stat = '0;
   logic [1:0]       stat;
   logic             irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   win_watch #(.MAG_W(MAG_W)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_val(smp_val),
      .lim_a(lim_a), .lim_b(lim_b), .clr_stat(clr_stat),
      .stat(stat), .irq(irq)
   );

   // limit word = {dir(1=above), sign(1=neg), mag[7:0]}
   // entry = {lim_a[9:0], lim_b[9:0], sample[8:0], expected stat[1:0]}
   localparam int NV = 14;
   localparam logic [30:0] VEC [NV] = '{
      {10'b1_0_00110010, 10'b0_1_00110010, 9'h03C, 2'b01},
      {10'b1_0_00110010, 10'b0_1_00110010, 9'h1C4, 2'b10},
      {10'b1_0_00110010, 10'b0_1_00110010, 9'h000, 2'b00},
      {10'b1_0_00110010, 10'b0_1_00110010, 9'h032, 2'b00},
      {10'b1_0_00110010, 10'b0_1_00110010, 9'h1CE, 2'b00},
      {10'b0_0_00110010, 10'b1_1_00110010, 9'h000, 2'b11},
      {10'b0_0_00110010, 10'b1_1_00110010, 9'h03C, 2'b10},
      {10'b0_0_00110010, 10'b1_1_00110010, 9'h1C4, 2'b01},
      {10'b1_1_00000000, 10'b0_0_00000000, 9'h000, 2'b00},
      {10'b1_1_00000000, 10'b0_0_00000000, 9'h001, 2'b01},
      {10'b1_1_00000000, 10'b0_0_00000000, 9'h1FF, 2'b10},
      {10'b1_1_11111111, 10'b0_0_11111111, 9'h100, 2'b10},
      {10'b1_1_11111111, 10'b0_0_11111111, 9'h0FF, 2'b01},
      {10'b1_1_11111111, 10'b0_0_11111111, 9'h101, 2'b10}
   };

   task automatic chk(input string req, input logic [1:0] act_s, input logic [1:0] exp_s);
      n_chk++;
      if (act_s !== exp_s || irq !== (|exp_s)) begin
         n_fail++;
         $display("FAIL %s stat=%b irq=%b expected stat=%b irq=%b",
                  req, act_s, irq, exp_s, |exp_s);
      end
   endtask

   task automatic pulse(input logic [MAG_W:0] v, input logic [1:0] clr);
      @(negedge clk);
      smp_val = v; smp_vld = 1'b1; clr_stat = clr;
      @(negedge clk);
      smp_vld = 1'b0; clr_stat = 2'b00;
   endtask

   task automatic clear_all();
      @(negedge clk);
      clr_stat = 2'b11;
      @(negedge clk);
      clr_stat = 2'b00;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", stat, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", stat, 2'b00);

      // table: R2 R3 R4 R10
      for (int k = 0; k < NV; k++) begin
         lim_a = VEC[k][30:21];
         lim_b = VEC[k][20:11];
         clear_all();
         pulse(VEC[k][10:2], 2'b00);
         chk($sformatf("R2/R3/R4/R10 vec%0d", k), stat, VEC[k][1:0]);
      end

      // outside band +/-50 for the directed part
      lim_a = 10'b1_0_00110010;
      lim_b = 10'b0_1_00110010;
      clear_all();

      // R5: tripping sample without strobe
      @(negedge clk);
      smp_val = 9'h03C; smp_vld = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 no strobe", stat, 2'b00);

      // R6: sticky across a quiet sample
      pulse(9'h03C, 2'b00);
      chk("R6 set", stat, 2'b01);
      pulse(9'h000, 2'b00);
      chk("R6 held", stat, 2'b01);
      repeat (2) @(negedge clk);
      chk("R6 idle held", stat, 2'b01);

      // R7: per-bit clear
      @(negedge clk); clr_stat = 2'b10;
      @(negedge clk); clr_stat = 2'b00;
      chk("R7 other bit clear", stat, 2'b01);
      @(negedge clk); clr_stat = 2'b01;
      @(negedge clk); clr_stat = 2'b00;
      chk("R7 own bit clear", stat, 2'b00);

      // R8: trip and clear on same edge
      pulse(9'h03C, 2'b00);
      pulse(9'h03C, 2'b01);
      chk("R8 set beats clear", stat, 2'b01);
      pulse(9'h1C4, 2'b11);
      chk("R8 mixed", stat, 2'b10);

      // R9: irq follows status through a full clear
      clear_all();
      chk("R9 irq low", stat, 2'b00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule